// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block sits between a controller and the gate drivers of an H-bridge built from two half-bridge legs. Each leg has its own pair of command bits: one asks for the high-side switch and one asks for the low-side switch. The block cleans each pair with a short glitch filter. It decodes the pair into one of three leg states: driven high, driven low, or floating. It then produces one gate-enable per switch. A pair that asks for both switches is treated as a request to float the leg, so the bridge can never short the supply.

Before a switch turns on, the leg waits through a dead interval during which both of its switches are off. The length of this interval is a base count plus a 3-bit slew code times a step, so slower edge settings get a longer guard. A command that changes during a dead interval restarts the interval toward the newest target. A sleep request or a fault-disable input turns every gate off in the same cycle, with no wait. After either one is released, a full dead interval must pass before any switch may turn on. A 2-bit status per leg reports which gate is on.

Top module: `hb_gate_ctrl`

## Requirements
- R1: Each leg decodes its filtered command pair {low-request, high-request} as follows: 01 drives high (only the high gate on), 10 drives low (only the low gate on), and 00 floats (both gates off). The leg's status field is {low gate, high gate}: 00 means floating, 01 means high, 10 means low. Leg n's status is at bits [2n+1:2n].
- R2: A command pair of 11 turns both gates of that leg off. The two gates of one leg are never on in the same cycle.
- R3: When no dead interval is pending, a gate follows its command GLITCH_CYC+2 rising clock edges after the first edge that samples the new command. The same latency applies when a gate turns off.
- R4: On a change from one switch to the other, both gates of the leg stay off for exactly BASE_CYC + slew_code*STEP_CYC cycles between the one turning off and the other turning on.
- R5: A command level that is sampled on GLITCH_CYC or fewer consecutive edges has no effect on the gates.
- R6: If the command changes to a new on-target during a dead interval, the interval restarts from the edge where the new command takes effect. The switch from the abandoned target never turns on.
- R7: While sleep_req is high, all gates are off from that same cycle, and command changes have no effect. After release, a gate turns on at the (BASE_CYC + slew_code*STEP_CYC)-th rising edge counted from the first edge that samples sleep_req low.
- R8: fault_off behaves like sleep_req: all gates are off at once, and a full dead interval is required after release.
- R9: The legs act independently. One leg can drive high while the other drives low.
- R10: A gate stays on for exactly as many cycles as its command level was held, for any hold of GLITCH_CYC+1 cycles or more. This lets pulse trains be followed cycle for cycle.
- R11: While reset is active and just after it, all gates are off and every status field reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Forces all gates off while high |
| fault_off | input | 1 | Fault-disable from the protection logic; forces all gates off while high |
| slew_code | input | 3 | Selects the added dead time (code times STEP_CYC) |
| cmd_hi | input | NUM_LEGS | High-side request, one bit per leg |
| cmd_lo | input | NUM_LEGS | Low-side request, one bit per leg |
| gate_hi | output | NUM_LEGS | High-side gate enable, one bit per leg |
| gate_lo | output | NUM_LEGS | Low-side gate enable, one bit per leg |
| leg_status | output | 2*NUM_LEGS | Per-leg state {low gate, high gate} |

## Verification
The dead interval is swept over all eight slew codes on both legs, in both switching directions. The measured off-gap tells a correct code-times-step interval apart from an off-by-one or a missing step. Short command pulses just under and just over the filter width separate a filter that accepts at GLITCH_CYC+1 samples from one that accepts too early or too late. Long pulse trains check that on-time equals command width. A command that changes in the middle of a dead interval shows whether the interval restarts or leaks the old target. The sleep and fault sequences, together with the 11 command, show that forcing is immediate and that a full interval is enforced after release.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
// Shared types for the H-bridge gate sequencer.
// Assumes: the command pair of a leg is packed as {low-request, high-request}.
package hb_pkg;
    typedef enum logic [1:0] {
        ST_HIZ  = 2'b00,
        ST_HIGH = 2'b01,
        ST_LOW  = 2'b10
    } leg_state_t;
endpackage

// File: rtl/hb_deglitch.sv
`timescale 1ns/1ps
// Glitch filter: a W-bit input reaches the output only once it has been
// sampled unchanged on GLITCH_CYC+1 consecutive edges.
// Assumes: din is synchronous to clk.
module hb_deglitch #(
    parameter int W          = 2,
    parameter int GLITCH_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

    logic [W-1:0]  cand_q;
    logic [W-1:0]  filt_q;
    logic [CW-1:0] cnt_q;

    // Track the candidate level and count how long it has been stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
            filt_q <= '0;
            cnt_q  <= LAST;
        end else if (din != cand_q) begin
            cand_q <= din;
            cnt_q  <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q  <= cnt_q + 1'b1;
        end else begin
            filt_q <= cand_q;
        end
    end

    assign dout = filt_q;

    // R5: the output only moves after the candidate has settled.
    p_filt_settled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(cnt_q) == LAST && $past(cand_q) == filt_q));
endmodule

// File: rtl/hb_leg.sv
`timescale 1ns/1ps
// One half-bridge leg: decodes the filtered command pair, sequences the
// dead interval and produces the two gate enables.
// Assumes: dead_len holds (interval length - 1) and is sampled when a dead
// interval is loaded; force_off is synchronous.
module hb_leg
    import hb_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cmd,
    input  logic          force_off,
    input  logic [CW-1:0] dead_len,
    output logic          gate_hi,
    output logic          gate_lo,
    output logic [1:0]    status
);
    leg_state_t    state_q, tgt_q, tgt_d;
    logic [CW-1:0] cnt_q;

    // Map the command pair to a target state; 11 floats the leg.
    always_comb begin
        unique case (cmd)
            2'b01:   tgt_d = ST_HIGH;
            2'b10:   tgt_d = ST_LOW;
            default: tgt_d = ST_HIZ;
        endcase
    end

    // Leg sequencer: turn off at once, turn on only after the dead count ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HIZ;
            tgt_q   <= ST_HIZ;
            cnt_q   <= '0;
        end else begin
            tgt_q <= tgt_d;
            if (force_off) begin
                state_q <= ST_HIZ;
                cnt_q   <= dead_len;
            end else if (state_q != ST_HIZ) begin
                if (tgt_d != state_q) begin
                    state_q <= ST_HIZ;
                    cnt_q   <= dead_len;
                end
            end else if (cnt_q != '0) begin
                if (tgt_d != tgt_q && tgt_d != ST_HIZ) cnt_q <= dead_len;
                else                                  cnt_q <= cnt_q - 1'b1;
            end else if (tgt_d != ST_HIZ) begin
                state_q <= tgt_d;
            end
        end
    end

    assign gate_hi = (state_q == ST_HIGH) && !force_off;
    assign gate_lo = (state_q == ST_LOW)  && !force_off;
    assign status  = {gate_lo, gate_hi};

    // R2: a both-on command floats the leg on the next edge.
    p_both_req_floats_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b11) |=> (state_q == ST_HIZ));
    // R4: a switch turns on only once the dead count has run out.
    p_on_after_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HIZ && $past(state_q) == ST_HIZ) |-> ($past(cnt_q) == '0));
    // R4: no direct change from one switch to the other.
    p_no_direct_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_HIZ && state_q != ST_HIZ) |-> (state_q == $past(state_q)));
    // R7 and R8: a forced cycle leaves the leg floating.
    p_forced_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(force_off) |-> (state_q == ST_HIZ));
endmodule

// File: rtl/hb_gate_ctrl.sv
`timescale 1ns/1ps
// H-bridge gate sequencer top: per-leg glitch filter and leg sequencer,
// shared dead-interval length from the slew code, global force-off.
// Assumes: all inputs synchronous to clk; BASE_CYC >= 1.
module hb_gate_ctrl
    import hb_pkg::*;
#(
    parameter int NUM_LEGS   = 2,
    parameter int GLITCH_CYC = 4,
    parameter int BASE_CYC   = 10,
    parameter int STEP_CYC   = 1400,
    parameter int SLEW_W     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_req,
    input  logic                  fault_off,
    input  logic [SLEW_W-1:0]     slew_code,
    input  logic [NUM_LEGS-1:0]   cmd_hi,
    input  logic [NUM_LEGS-1:0]   cmd_lo,
    output logic [NUM_LEGS-1:0]   gate_hi,
    output logic [NUM_LEGS-1:0]   gate_lo,
    output logic [2*NUM_LEGS-1:0] leg_status
);
    localparam int DEAD_MAX = BASE_CYC + (2**SLEW_W - 1) * STEP_CYC;
    localparam int DCW      = $clog2(DEAD_MAX + 1);

    logic [DCW-1:0] dead_len;
    logic           force_off;

    // Dead interval minus one, as loaded into each leg counter.
    always_comb dead_len = DCW'(BASE_CYC - 1) + DCW'(slew_code) * DCW'(STEP_CYC);

    assign force_off = sleep_req | fault_off;

    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
        logic [1:0] cmd_f;

        hb_deglitch #(.W(2), .GLITCH_CYC(GLITCH_CYC)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  ({cmd_lo[i], cmd_hi[i]}),
            .dout (cmd_f)
        );

        hb_leg #(.CW(DCW)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd_f),
            .force_off(force_off),
            .dead_len (dead_len),
            .gate_hi  (gate_hi[i]),
            .gate_lo  (gate_lo[i]),
            .status   (leg_status[2*i +: 2])
        );
    end
endmodule

// File: tb/sim_hb_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hb_gate_ctrl;
    localparam int G    = 4;
    localparam int BASE = 10;
    localparam int STEP = 3;
    localparam int LAT  = G + 2;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       sleep_req = 0;
    logic       fault_off = 0;
    logic [2:0] slew_code = 0;
    logic [1:0] cmd_hi = 0, cmd_lo = 0;
    logic [1:0] gate_hi, gate_lo;
    logic [3:0] leg_status;

    int n_chk = 0, n_fail = 0, hi_cnt = 0;
    bit done = 0;

    hb_gate_ctrl #(.NUM_LEGS(2), .GLITCH_CYC(G), .BASE_CYC(BASE), .STEP_CYC(STEP), .SLEW_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .fault_off(fault_off),
        .slew_code(slew_code), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .leg_status(leg_status));

    always #10 clk = ~clk;

    always @(negedge clk) if (gate_hi[0]) hi_cnt++;

    function automatic int dead(input int c);
        return BASE + c * STEP;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_leg(input int l, input bit lo, input bit hi);
        cmd_lo[l] = lo;
        cmd_hi[l] = hi;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count rising edges until the chosen gate reaches val; note the other gate.
    task automatic wait_gate(input int l, input bit hi_side, input bit val,
                             output int n, output bit other);
        n = 0;
        other = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
            if (hi_side ? gate_lo[l] : gate_hi[l]) other = 1;
        end while (((hi_side ? gate_hi[l] : gate_lo[l]) != val) && n < 3000);
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(150000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_up();
        end
    end

    initial begin
        int n;
        bit o;
        // R11: reset state
        idle(3);
        check(gate_hi == 0 && gate_lo == 0, "R11 gates", {gate_lo, gate_hi}, 0);
        rst_n = 1;
        idle(2);
        check(leg_status == 0, "R11 status", leg_status, 0);

        // R1, R3, R4: dead interval over all codes, both legs
        for (int l = 0; l < 2; l++) begin
            for (int c = 0; c < 8; c++) begin
                slew_code = 3'(c);
                set_leg(l, 0, 1);
                wait_gate(l, 1, 1, n, o);
                check(n == LAT, "R3 on", n, LAT);
                check(leg_status[2*l +: 2] == 2'b01, "R1 high", leg_status[2*l +: 2], 1);
                set_leg(l, 1, 0);
                wait_gate(l, 1, 0, n, o);
                check(n == LAT, "R3 off", n, LAT);
                wait_gate(l, 0, 1, n, o);
                check(n == dead(c) && !o, "R4 gap", n, dead(c));
                check(leg_status[2*l +: 2] == 2'b10, "R1 low", leg_status[2*l +: 2], 2);
                set_leg(l, 0, 0);
                wait_gate(l, 0, 0, n, o);
                check(leg_status[2*l +: 2] == 2'b00, "R1 float", leg_status[2*l +: 2], 0);
                idle(40);
            end
        end

        // R2: both-on request floats the leg
        slew_code = 0;
        set_leg(0, 0, 1);
        wait_gate(0, 1, 1, n, o);
        set_leg(0, 1, 1);
        wait_gate(0, 1, 0, n, o);
        check(n == LAT, "R2 off latency", n, LAT);
        idle(30);
        check(gate_hi[0] == 0 && gate_lo[0] == 0, "R2 stays off", {gate_lo[0], gate_hi[0]}, 0);
        set_leg(0, 0, 0);
        idle(40);

        // R6: restart during dead interval
        slew_code = 7;
        set_leg(0, 0, 1);
        wait_gate(0, 1, 1, n, o);
        set_leg(0, 1, 0);
        wait_gate(0, 1, 0, n, o);
        idle(5);
        set_leg(0, 0, 1);
        wait_gate(0, 1, 1, n, o);
        check(n == LAT + dead(7) && !o, "R6 restart", n, LAT + dead(7));
        set_leg(0, 0, 0);
        idle(60);

        // R5: short pulses ignored, G+1 accepted
        slew_code = 0;
        set_leg(1, 0, 1);
        idle(G);
        set_leg(1, 0, 0);
        o = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (gate_hi[1] || gate_lo[1]) o = 1;
        end
        check(!o, "R5 pulse ignored", o, 0);
        set_leg(1, 1, 0);
        idle(G - 1);
        set_leg(1, 0, 0);
        o = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (gate_hi[1] || gate_lo[1]) o = 1;
        end
        check(!o, "R5 pulse ignored low", o, 0);
        set_leg(1, 0, 1);
        idle(G + 1);
        set_leg(1, 0, 0);
        o = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (gate_hi[1]) o = 1;
        end
        check(o, "R5 pulse accepted", o, 1);
        idle(40);

        // R10: on-time equals command width
        foreach (hi_cnt_w[i]) begin
            hi_cnt = 0;
            set_leg(0, 0, 1);
            idle(hi_cnt_w[i]);
            set_leg(0, 0, 0);
            idle(60);
            check(hi_cnt == hi_cnt_w[i], "R10 width", hi_cnt, hi_cnt_w[i]);
        end
        hi_cnt = 0;
        for (int p = 0; p < 2; p++) begin
            set_leg(0, 0, 1);
            idle(1000);
            set_leg(0, 0, 0);
            idle(1000);
        end
        check(hi_cnt == 2000, "R10 pulse train", hi_cnt, 2000);

        // R9: legs independent
        set_leg(0, 0, 1);
        set_leg(1, 1, 0);
        idle(LAT + 4);
        check(gate_hi == 2'b01 && gate_lo == 2'b10, "R9 gates", {gate_lo, gate_hi}, 4'b1001);
        check(leg_status == 4'b1001, "R9 status", leg_status, 4'b1001);

        // R7: sleep forces off at once, ignores commands, full interval after release
        slew_code = 2;
        sleep_req = 1;
        #1;
        check(gate_hi == 0 && gate_lo == 0, "R7 immediate", {gate_lo, gate_hi}, 0);
        @(negedge clk);
        set_leg(0, 1, 0);
        set_leg(1, 0, 1);
        o = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (gate_hi != 0 || gate_lo != 0) o = 1;
        end
        check(!o, "R7 ignored", o, 0);
        sleep_req = 0;
        wait_gate(0, 0, 1, n, o);
        check(n == dead(2) && !o, "R7 release", n, dead(2));
        check(gate_hi[1] == 1, "R7 release leg1", gate_hi[1], 1);

        // R8: fault-disable behaves the same
        slew_code = 5;
        fault_off = 1;
        #1;
        check(gate_hi == 0 && gate_lo == 0, "R8 immediate", {gate_lo, gate_hi}, 0);
        @(negedge clk);
        idle(20);
        check(leg_status == 0, "R8 status", leg_status, 0);
        fault_off = 0;
        wait_gate(1, 1, 1, n, o);
        check(n == dead(5) && !o, "R8 release", n, dead(5));
        check(gate_lo[0] == 1, "R8 release leg0", gate_lo[0], 1);

        done = 1;
        finish_up();
    end

    int hi_cnt_w[4] = '{G + 1, G + 3, 50, 1000};
endmodule